// File: doc/BRIEF.md
# Machine-Mode CSR Unit with Interrupt Entry

This block holds the four machine-mode control and status registers of a small three-stage (fetch, decode, execute) pipeline: the status word with its global interrupt enable and saved enable, the trap vector base, the exception return address and the cause word. It serves the CSR read-modify-write instructions issued from the execute stage. Each such instruction returns the register's old value for the destination integer register, and the register takes its new value at the next clock edge.

It also watches an external interrupt request. When the request is high, interrupts are enabled and a valid instruction sits in execute, the unit takes the interrupt in that cycle. The instruction in execute is cancelled and its pc is saved as the return address. The cause is recorded and the global enable is cleared. The same cycle redirects fetch to the trap vector and flushes the fetch and decode slots. A return-from-trap instruction in execute restores the enable and redirects fetch to the saved return address.

Top module: `csr_trap_unit`

## Requirements
- R1: After reset all four CSRs read zero, so interrupts are disabled, and no redirect, flush or squash is signalled.
- R2: `csr_op` uses funct3 encoding. Bit 2 selects the 5-bit zero-extended immediate instead of `csr_src`, and bits 1:0 select the operation: 01 swap, 10 set, 11 clear, 00 none. For swap, `csr_rdata` shows the old value in the issue cycle and the register holds the operand from the next cycle.
- R3: For set, the new value is the old value OR the operand. A zero operand leaves the register unchanged.
- R4: For clear, the new value is the old value AND the inverted operand. A zero operand leaves the register unchanged.
- R5: The addresses are status 0x300, vector 0x305, return address 0x341 and cause 0x342. In the status word only bit 3 (enable) and bit 7 (saved enable) are stored and the other bits read 0. Bits 1:0 of the vector and of the return address read 0. Any other address reads 0 and ignores writes.
- R6: An interrupt is taken only when `irq_ext`, the status enable bit and `exe_valid` are all 1.
- R7: Taking an interrupt sets the return address to `exe_pc` with bits 1:0 cleared, the cause to 0x8000000B (bit 31 marks an interrupt, external code 11), the saved enable to the old enable, and the enable to 0.
- R8: In the cycle an interrupt is taken, `redirect_valid`, `flush_front` and `squash_exe` are 1 and `redirect_pc` equals the vector register.
- R9: A CSR write issued in the same cycle as an interrupt is discarded.
- R10: A valid return-from-trap with no interrupt asserts `redirect_valid` and `flush_front`, keeps `squash_exe` at 0, and sets `redirect_pc` to the return address. From the next cycle the enable equals the old saved enable and the saved enable is 1.
- R11: When an interrupt and a return-from-trap meet in execute, the interrupt wins, and the return address becomes the pc of the return instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exe_valid | input | 1 | A real instruction occupies execute |
| exe_pc | input | 32 | pc of the instruction in execute |
| exe_is_mret | input | 1 | Instruction in execute is return-from-trap |
| csr_valid | input | 1 | Instruction in execute is a CSR access |
| csr_op | input | 3 | funct3-style operation code |
| csr_addr | input | 12 | CSR address |
| csr_src | input | 32 | Register source operand |
| csr_zimm | input | 5 | Immediate source operand |
| irq_ext | input | 1 | External interrupt request |
| csr_rdata | output | 32 | Old value of the addressed CSR |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | New fetch address |
| flush_front | output | 1 | Clear the fetch and decode slots |
| squash_exe | output | 1 | Cancel the instruction in execute |

## Verification
`csr_rdata`, `redirect_valid`, `redirect_pc`, `flush_front` and `squash_exe` are combinational and due in the cycle the stimulus is applied. Register updates from CSR writes, interrupt entry and return show up one cycle later, through a read at the next issue. The driver applies each cycle's inputs just after a rising edge and queues the expected values from its own register model. The monitor takes them off the queue at the falling edge of the same cycle, and the model is advanced only after the rising edge that ends the cycle. A value written in one cycle is therefore expected only from the following cycle's read.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;
  localparam int unsigned XLEN = 32;

  localparam logic [11:0] ADR_STATUS = 12'h300;
  localparam logic [11:0] ADR_VECTOR = 12'h305;
  localparam logic [11:0] ADR_RETPC  = 12'h341;
  localparam logic [11:0] ADR_CAUSE  = 12'h342;

  localparam int unsigned BIT_EN      = 3;
  localparam int unsigned BIT_SAVE_EN = 7;

  typedef enum logic [1:0] {
    RMW_NONE = 2'b00,
    RMW_SWAP = 2'b01,
    RMW_SET  = 2'b10,
    RMW_CLR  = 2'b11
  } rmw_kind_e;

  function automatic logic [XLEN-1:0] rmw_result(rmw_kind_e k,
                                                 logic [XLEN-1:0] old_v,
                                                 logic [XLEN-1:0] opnd);
    case (k)
      RMW_SWAP: return opnd;
      RMW_SET:  return old_v | opnd;
      RMW_CLR:  return old_v & ~opnd;
      default:  return old_v;
    endcase
  endfunction

  function automatic logic rmw_writes(rmw_kind_e k, logic [XLEN-1:0] opnd);
    case (k)
      RMW_SWAP:         return 1'b1;
      RMW_SET, RMW_CLR: return |opnd;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] cause_word(int unsigned code);
    logic [XLEN-1:0] w;
    w = XLEN'(code);
    w[XLEN-1] = 1'b1;
    return w;
  endfunction

  function automatic logic [XLEN-1:0] align_word(logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction
endpackage

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_trap_pkg::*;
#(
  parameter int unsigned ZIMM_W = 5
) (
  input  logic [2:0]        op,
  input  logic [XLEN-1:0]   src,
  input  logic [ZIMM_W-1:0] zimm,
  input  logic [XLEN-1:0]   old_value,
  output logic [XLEN-1:0]   new_value,
  output logic              wants_write
);
  rmw_kind_e       kind;
  logic [XLEN-1:0] operand;

  always_comb begin
    kind        = rmw_kind_e'(op[1:0]);
    operand     = op[2] ? XLEN'(zimm) : src;
    new_value   = rmw_result(kind, old_value, operand);
    wants_write = rmw_writes(kind, operand);
  end

  // R3
  always_comb begin
    if (kind == RMW_SET && wants_write)
      set_keeps_bits_chk: assert ((new_value & old_value) == old_value);
  end

  // R4
  always_comb begin
    if (kind == RMW_CLR && wants_write)
      clr_drops_bits_chk: assert ((new_value & operand) == '0);
  end
endmodule

// File: rtl/csr_trap_arbiter.sv
module csr_trap_arbiter
  import csr_trap_pkg::*;
(
  input  logic            irq_ext,
  input  logic            irq_enabled,
  input  logic            exe_valid,
  input  logic            exe_is_mret,
  input  logic            csr_valid,
  input  logic            wants_write,
  input  logic [XLEN-1:0] vector_base,
  input  logic [XLEN-1:0] return_pc,
  output logic            take_irq,
  output logic            mret_fire,
  output logic            csr_we,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            flush_front,
  output logic            squash_exe
);
  always_comb begin
    take_irq       = irq_ext & irq_enabled & exe_valid;
    mret_fire      = exe_valid & exe_is_mret & ~take_irq;
    csr_we         = exe_valid & csr_valid & wants_write & ~take_irq;
    redirect_valid = take_irq | mret_fire;
    redirect_pc    = take_irq ? vector_base : return_pc;
    flush_front    = redirect_valid;
    squash_exe     = take_irq;
  end

  // R9
  always_comb begin
    if (take_irq) entry_blocks_write_chk: assert (!csr_we);
  end

  // R11
  always_comb begin
    if (take_irq) entry_beats_return_chk: assert (!mret_fire);
  end
endmodule

// File: rtl/csr_reg_bank.sv
module csr_reg_bank
  import csr_trap_pkg::*;
#(
  parameter int unsigned IRQ_CODE = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_irq,
  input  logic [XLEN-1:0] trap_pc,
  input  logic            mret_fire,
  input  logic            we,
  input  logic [11:0]     addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  output logic            irq_enabled,
  output logic [XLEN-1:0] vector_base,
  output logic [XLEN-1:0] return_pc
);
  localparam logic [XLEN-1:0] CAUSE_EXT = cause_word(IRQ_CODE);

  logic            en_q, save_en_q;
  logic [XLEN-1:0] vec_q, epc_q, cause_q;
  logic [XLEN-1:0] status_word;

  always_comb begin
    status_word              = '0;
    status_word[BIT_EN]      = en_q;
    status_word[BIT_SAVE_EN] = save_en_q;
    case (addr)
      ADR_STATUS: rdata = status_word;
      ADR_VECTOR: rdata = vec_q;
      ADR_RETPC:  rdata = epc_q;
      ADR_CAUSE:  rdata = cause_q;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      save_en_q <= 1'b0;
      vec_q     <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
    end else if (take_irq) begin
      epc_q     <= align_word(trap_pc);
      cause_q   <= CAUSE_EXT;
      save_en_q <= en_q;
      en_q      <= 1'b0;
    end else begin
      if (mret_fire) begin
        en_q      <= save_en_q;
        save_en_q <= 1'b1;
      end
      if (we) begin
        case (addr)
          ADR_STATUS: begin
            en_q      <= wdata[BIT_EN];
            save_en_q <= wdata[BIT_SAVE_EN];
          end
          ADR_VECTOR: vec_q   <= align_word(wdata);
          ADR_RETPC:  epc_q   <= align_word(wdata);
          ADR_CAUSE:  cause_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq_enabled = en_q;
  assign vector_base = vec_q;
  assign return_pc   = epc_q;

  // R7
  entry_clears_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (!en_q && save_en_q == $past(en_q)));

  // R7
  entry_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> (epc_q == {$past(trap_pc[XLEN-1:2]), 2'b00} && cause_q[XLEN-1]));

  // R9
  entry_keeps_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> $stable(vec_q));

  // R10
  return_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_fire && !we) |=> (en_q == $past(save_en_q) && save_en_q));

  // R6
  enable_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !$past(take_irq)) |-> en_q);
endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
  import csr_trap_pkg::*;
#(
  parameter int unsigned IRQ_CODE = 11,
  parameter int unsigned ZIMM_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exe_valid,
  input  logic [31:0]       exe_pc,
  input  logic              exe_is_mret,
  input  logic              csr_valid,
  input  logic [2:0]        csr_op,
  input  logic [11:0]       csr_addr,
  input  logic [31:0]       csr_src,
  input  logic [ZIMM_W-1:0] csr_zimm,
  input  logic              irq_ext,
  output logic [31:0]       csr_rdata,
  output logic              redirect_valid,
  output logic [31:0]       redirect_pc,
  output logic              flush_front,
  output logic              squash_exe
);
  logic            take_irq, mret_fire, csr_we, wants_write, irq_enabled;
  logic [XLEN-1:0] new_value, vector_base, return_pc, old_value;

  csr_rmw_unit #(.ZIMM_W(ZIMM_W)) u_rmw (
    .op(csr_op), .src(csr_src), .zimm(csr_zimm), .old_value(old_value),
    .new_value(new_value), .wants_write(wants_write)
  );

  csr_trap_arbiter u_arb (
    .irq_ext(irq_ext), .irq_enabled(irq_enabled), .exe_valid(exe_valid),
    .exe_is_mret(exe_is_mret), .csr_valid(csr_valid), .wants_write(wants_write),
    .vector_base(vector_base), .return_pc(return_pc), .take_irq(take_irq),
    .mret_fire(mret_fire), .csr_we(csr_we), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .flush_front(flush_front), .squash_exe(squash_exe)
  );

  csr_reg_bank #(.IRQ_CODE(IRQ_CODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .take_irq(take_irq), .trap_pc(exe_pc),
    .mret_fire(mret_fire), .we(csr_we), .addr(csr_addr), .wdata(new_value),
    .rdata(old_value), .irq_enabled(irq_enabled), .vector_base(vector_base),
    .return_pc(return_pc)
  );

  assign csr_rdata = old_value;

  // R8
  redirect_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> flush_front);

  // R8
  squash_only_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash_exe |-> (redirect_valid && irq_ext));
endmodule

// File: tb/test_csr_trap_unit.sv
module test_csr_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exe_valid = 1'b0, exe_is_mret = 1'b0, csr_valid = 1'b0, irq_ext = 1'b0;
  logic [31:0] exe_pc = '0, csr_src = '0;
  logic [2:0]  csr_op = '0;
  logic [11:0] csr_addr = '0;
  logic [4:0]  csr_zimm = '0;
  logic [31:0] csr_rdata, redirect_pc;
  logic        redirect_valid, flush_front, squash_exe;

  csr_trap_unit i_csr_trap_unit (.*);

  always #5 clk = ~clk;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } item_t;
  item_t sb[$];

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of the registers
  bit          m_en, m_sen;
  logic [31:0] m_vec, m_epc, m_cause;

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      12'h300: return (32'(m_sen) << 7) | (32'(m_en) << 3);
      12'h305: return m_vec;
      12'h341: return m_epc;
      12'h342: return m_cause;
      default: return 32'h0;
    endcase
  endfunction

  task automatic push(string r, int s, logic [31:0] e);
    item_t it;
    it.req = r; it.sel = s; it.exp = e;
    sb.push_back(it);
  endtask

  task automatic cycle(bit cv, logic [2:0] op, logic [11:0] a, logic [31:0] src,
                       logic [4:0] zi, bit ev, logic [31:0] pc, bit mr, bit irq,
                       string r);
    bit          take, ret;
    logic [31:0] opnd, oldv, nv;
    bit          wr;
    csr_valid = cv; csr_op = op; csr_addr = a; csr_src = src; csr_zimm = zi;
    exe_valid = ev; exe_pc = pc; exe_is_mret = mr; irq_ext = irq;
    take = irq && m_en && ev;
    ret  = ev && mr && !take;
    oldv = m_read(a);
    push(r, 0, oldv);
    push(r, 1, 32'(take || ret));
    push(r, 3, 32'(take || ret));
    push(r, 4, 32'(take));
    if (take) push(r, 2, m_vec);
    else if (ret) push(r, 2, m_epc);
    opnd = op[2] ? {27'd0, zi} : src;
    case (op[1:0])
      2'b01: begin nv = opnd; wr = 1; end
      2'b10: begin nv = oldv | opnd; wr = (opnd != 0); end
      2'b11: begin nv = oldv & ~opnd; wr = (opnd != 0); end
      default: begin nv = oldv; wr = 0; end
    endcase
    @(posedge clk);
    if (take) begin
      m_epc = pc & 32'hFFFF_FFFC; m_cause = 32'h8000_000B; m_sen = m_en; m_en = 0;
    end else begin
      if (ret) begin m_en = m_sen; m_sen = 1; end
      if (cv && ev && wr) begin
        case (a)
          12'h300: begin m_en = nv[3]; m_sen = nv[7]; end
          12'h305: m_vec = nv & 32'hFFFF_FFFC;
          12'h341: m_epc = nv & 32'hFFFF_FFFC;
          12'h342: m_cause = nv;
          default: ;
        endcase
      end
    end
    #1;
  endtask

  task automatic csr(logic [2:0] op, logic [11:0] a, logic [31:0] src, logic [4:0] zi,
                     string r);
    cycle(1, op, a, src, zi, 1, 32'h0000_1000, 0, 0, r);
  endtask

  task automatic idle(logic [11:0] a, string r);
    cycle(0, 3'b000, a, 0, 0, 0, 0, 0, 0, r);
  endtask

  // monitor: compares queued expectations in the same cycle
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.sel)
        0: act = csr_rdata;
        1: act = 32'(redirect_valid);
        2: act = redirect_pc;
        3: act = 32'(flush_front);
        default: act = 32'(squash_exe);
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_sen = 0; m_vec = 0; m_epc = 0; m_cause = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset values
    idle(12'h300, "R1"); idle(12'h305, "R1"); idle(12'h341, "R1"); idle(12'h342, "R1");
    // R2 swap and R5 alignment
    csr(3'b001, 12'h305, 32'h0000_0103, 0, "R2");
    idle(12'h305, "R5");
    csr(3'b001, 12'h342, 32'hDEAD_BEEF, 0, "R2");
    csr(3'b101, 12'h342, 0, 5'd9, "R2");
    idle(12'h342, "R2");
    // R3 set, R5 status mask
    csr(3'b010, 12'h300, 32'hFFFF_FFFF, 0, "R3");
    idle(12'h300, "R5");
    csr(3'b110, 12'h300, 0, 5'd0, "R3");
    idle(12'h300, "R3");
    // R4 clear
    csr(3'b111, 12'h300, 0, 5'd8, "R4");
    idle(12'h300, "R4");
    csr(3'b011, 12'h305, 0, 0, "R4");
    idle(12'h305, "R4");
    // R5 unknown address
    csr(3'b001, 12'h340, 32'h1234_5678, 0, "R5");
    idle(12'h340, "R5");
    csr(3'b001, 12'h341, 32'h0000_1237, 0, "R5");
    idle(12'h341, "R5");
    // R6 disabled / no valid instruction
    cycle(0, 0, 12'h300, 0, 0, 1, 32'h2000, 0, 1, "R6");
    csr(3'b110, 12'h300, 0, 5'd8, "R6");
    cycle(0, 0, 12'h300, 0, 0, 0, 32'h2000, 0, 1, "R6");
    // R8 entry with R9 simultaneous write
    cycle(1, 3'b001, 12'h305, 32'h400, 0, 1, 32'h2006, 0, 1, "R8");
    idle(12'h341, "R7"); idle(12'h342, "R7"); idle(12'h300, "R7"); idle(12'h305, "R9");
    // R6 enable now clear
    cycle(0, 0, 12'h300, 0, 0, 1, 32'h2100, 0, 1, "R6");
    // R10 return
    cycle(0, 0, 12'h341, 0, 0, 1, 32'h2200, 1, 0, "R10");
    idle(12'h300, "R10");
    // R11 return meets interrupt
    cycle(0, 0, 12'h341, 0, 0, 1, 32'h3000, 1, 1, "R11");
    idle(12'h341, "R11"); idle(12'h300, "R11");
    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule